// File: doc/BRIEF.md
# Attribute Register Port with Index/Data Toggle

This block stores the attribute register set of a display controller behind a single write address. A hidden one-bit phase flag decides how each write is used. In the index phase, the write selects a register. In the data phase, the write fills the selected register. Every write flips the phase.

Software cannot read the phase flag. A read of the separate input-status port returns the flag to the index phase, so a driver always has a known starting point.

A separate read port returns one of two values: the current index byte, or the register it selects. The register set holds:
- sixteen 6-bit palette entries;
- an 8-bit mode word;
- an 8-bit border colour;
- a 6-bit plane-enable word;
- a 4-bit pan count;
- a 4-bit colour-select word.

Bit 5 of the index is the palette source bit. While it is clear, the palette can be loaded and the display is blanked. While it is set, the palette is in use and cannot be written.

Top module: `attr_ctrl`

## Requirements
- R1: After reset the phase is index, the index byte is 0x00, every register reads 0x00, `pal_src` is 0 and `blank` is 1.
- R2: A write in the index phase stores `wr_data[5:0]` as the index and moves to the data phase. Bits 7:6 are dropped.
- R3: A write in the data phase stores `wr_data` into the register selected by index bits 4:0 and moves back to the index phase.
- R4: `status_rd` forces the index phase at that edge. A write in the same cycle is first handled under the phase that held before the edge.
- R5: With `rd_en` high and `rd_sel`=1, `rd_data` shows the selected register one cycle later. A read never changes the phase.
- R6: With `rd_en` high and `rd_sel`=0, `rd_data` shows `{2'b00, index[5:0]}` one cycle later, including the source bit. `rd_data` holds its value while `rd_en` is low.
- R7: Register selection and widths:
  - index 0x00 to 0x0F selects a palette entry, which keeps bits 5:0;
  - 0x10 selects the mode word, whose bit 4 is reserved and reads 0;
  - 0x11 selects the border colour, all 8 bits;
  - 0x12 selects the plane-enable word, which keeps bits 5:0;
  - 0x13 selects the pan count and 0x14 the colour-select word, each keeping bits 3:0.
  - Reserved bits read as 0.
- R8: A data write to an index from 0x15 to 0x1F changes no register. A read of such an index returns 0x00.
- R9: While index bit 5 is 1, data writes to palette indices are ignored. Writes to indices 0x10 to 0x14 still take effect.
- R10: `pal_src` equals index bit 5, and `blank` is 1 exactly when index bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data address |
| wr_data | input | 8 | Write byte |
| status_rd | input | 1 | Read strobe of the input-status port; returns the phase to index |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects the index byte, 1 selects the indexed register |
| rd_data | output | 8 | Registered read value |
| pal_src | output | 1 | Palette source bit (index bit 5) |
| blank | output | 1 | High while the palette is open for loading |

## Verification
The assertions take for granted that `wr_en`, `status_rd`, `rd_en` and `rd_sel` are known, two-valued levels in every cycle after reset. They also assume each strobe is sampled once per edge, with no requirement that strobes be exclusive.

The stimulus drives all inputs at the falling edge, every cycle, from a fixed-seed random source. It lets write, status-read and read coincide freely, so the same-edge ordering rule is exercised. Index bytes are drawn mostly from 0x00 to 0x17 with bit 5 random, so that out-of-range indices and the palette lock both occur often.

// File: rtl/attr_pkg.sv
package attr_pkg;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 5;
    localparam int PTR_W     = IDX_W + 1;
    localparam int PAL_COUNT = 16;
    localparam int PAL_W     = 6;
    localparam int PLANE_W   = 6;
    localparam int PAN_W     = 4;
    localparam int CSEL_W    = 4;
    localparam int PSEL_W    = $clog2(PAL_COUNT);

    localparam logic [IDX_W-1:0] IX_PAL_LAST = IDX_W'(PAL_COUNT - 1);
    localparam logic [IDX_W-1:0] IX_MODE     = IDX_W'(PAL_COUNT);
    localparam logic [IDX_W-1:0] IX_BORDER   = IDX_W'(PAL_COUNT + 1);
    localparam logic [IDX_W-1:0] IX_PLANE    = IDX_W'(PAL_COUNT + 2);
    localparam logic [IDX_W-1:0] IX_PAN      = IDX_W'(PAL_COUNT + 3);
    localparam logic [IDX_W-1:0] IX_CSEL     = IDX_W'(PAL_COUNT + 4);

    localparam logic [DATA_W-1:0] MODE_KEEP  = 8'hEF;

    typedef struct packed {
        logic             data_ph;
        logic [PTR_W-1:0] ptr;
    } phase_t;
endpackage

// File: rtl/attr_phase.sv
module attr_phase
    import attr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic             status_rd,
    output logic             data_ph,
    output logic [PTR_W-1:0] ptr,
    output logic             data_wr
);
    phase_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        data_wr = wr_en && st_q.data_ph;
        if (wr_en) begin
            if (!st_q.data_ph) begin
                st_d.ptr = ptr_in;
            end
            st_d.data_ph = !st_q.data_ph;
        end
        if (status_rd) begin
            st_d.data_ph = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_ph = st_q.data_ph;
    assign ptr     = st_q.ptr;
endmodule

// File: rtl/attr_store.sv
module attr_store
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sel_val
);
    typedef struct packed {
        logic [PAL_COUNT-1:0][PAL_W-1:0] pal;
        logic [DATA_W-1:0]               mode;
        logic [DATA_W-1:0]               border;
        logic [PLANE_W-1:0]              plane;
        logic [PAN_W-1:0]                pan;
        logic [CSEL_W-1:0]               csel;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [IDX_W-1:0]     ix;
    logic                 locked;
    logic                 in_pal;
    logic [PAL_COUNT-1:0] pal_hit;

    assign ix     = ptr[IDX_W-1:0];
    assign locked = ptr[PTR_W-1];
    assign in_pal = (ix <= IX_PAL_LAST);

    for (genvar g = 0; g < PAL_COUNT; g++) begin : g_pal_hit
        assign pal_hit[g] = data_wr && !locked && (ix == IDX_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int k = 0; k < PAL_COUNT; k++) begin
            if (pal_hit[k]) begin
                bank_d.pal[k] = wr_data[PAL_W-1:0];
            end
        end
        if (data_wr && !in_pal) begin
            case (ix)
                IX_MODE:   bank_d.mode   = wr_data & MODE_KEEP;
                IX_BORDER: bank_d.border = wr_data;
                IX_PLANE:  bank_d.plane  = wr_data[PLANE_W-1:0];
                IX_PAN:    bank_d.pan    = wr_data[PAN_W-1:0];
                IX_CSEL:   bank_d.csel   = wr_data[CSEL_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        sel_val = '0;
        if (in_pal) begin
            sel_val = DATA_W'(bank_q.pal[ix[PSEL_W-1:0]]);
        end else begin
            case (ix)
                IX_MODE:   sel_val = bank_q.mode;
                IX_BORDER: sel_val = bank_q.border;
                IX_PLANE:  sel_val = DATA_W'(bank_q.plane);
                IX_PAN:    sel_val = DATA_W'(bank_q.pan);
                IX_CSEL:   sel_val = DATA_W'(bank_q.csel);
                default:   sel_val = '0;
            endcase
        end
    end
endmodule

// File: rtl/attr_ctrl.sv
module attr_ctrl
    import attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              status_rd,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              pal_src,
    output logic              blank
);
    logic             data_ph;
    logic [PTR_W-1:0] ptr;
    logic             data_wr;
    logic [DATA_W-1:0] sel_val;
    logic [DATA_W-1:0] rd_d, rd_q;

    attr_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .ptr_in    (wr_data[PTR_W-1:0]),
        .status_rd (status_rd),
        .data_ph   (data_ph),
        .ptr       (ptr),
        .data_wr   (data_wr)
    );

    attr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .ptr     (ptr),
        .wr_data (wr_data),
        .sel_val (sel_val)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = rd_sel ? sel_val : DATA_W'(ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;
    assign pal_src = ptr[PTR_W-1];
    assign blank   = !ptr[PTR_W-1];
endmodule

// File: rtl/attr_ctrl_chk.sv
module attr_ctrl_chk
    import attr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              status_rd,
    input logic              rd_en,
    input logic              rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              pal_src,
    input logic              blank,
    input logic              data_ph,
    input logic [PTR_W-1:0]  ptr
);
    a_r2_index_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !data_ph && !status_rd) |=> data_ph);

    a_r3_data_to_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && data_ph) |=> !data_ph);

    a_r4_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !data_ph);

    a_r5_read_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !status_rd) |=> $stable(data_ph));

    a_r6_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel) |=> (rd_data == DATA_W'($past(ptr))));

    a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r10_blank_vs_src: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_src != blank));
endmodule

bind attr_ctrl attr_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .status_rd (status_rd),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .pal_src   (pal_src),
    .blank     (blank),
    .data_ph   (data_ph),
    .ptr       (ptr)
);

// File: tb/attr_ctrl_bench.sv
`timescale 1ns/1ps
module attr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       status_rd = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       pal_src;
    logic       blank;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic       m_ph;
    logic [5:0] m_idx;
    logic [7:0] m_reg [0:31];

    always #4 clk = ~clk;

    attr_ctrl u_attr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .status_rd(status_rd), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .pal_src(pal_src), .blank(blank)
    );

    function automatic logic [7:0] keep_mask(input int i);
        if (i < 16)  return 8'h3F;
        if (i == 16) return 8'hEF;
        if (i == 17) return 8'hFF;
        if (i == 18) return 8'h3F;
        if (i == 19 || i == 20) return 8'h0F;
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ph  = 1'b0;
        m_idx = 6'h00;
        for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    endtask

    task automatic cyc(input logic w, input logic [7:0] d, input logic s,
                       input logic r, input logic sel, input string tag);
        logic [7:0] exp_rd;
        int i;
        @(negedge clk);
        wr_en = w; wr_data = d; status_rd = s; rd_en = r; rd_sel = sel;
        exp_rd = sel ? m_reg[m_idx[4:0]] : {2'b00, m_idx};
        @(posedge clk);
        if (w) begin
            if (!m_ph) begin
                m_idx = d[5:0];
            end else begin
                i = int'(m_idx[4:0]);
                if ((i < 16 && !m_idx[5]) || (i >= 16 && i <= 20))
                    m_reg[i] = d & keep_mask(i);
            end
            m_ph = !m_ph;
        end
        if (s) m_ph = 1'b0;
        #2;
        if (r) check(tag, rd_data, exp_rd);
        check("R10 pal_src", {7'd0, pal_src}, {7'd0, m_idx[5]});
        check("R10 blank", {7'd0, blank}, {7'd0, !m_idx[5]});
    endtask

    task automatic put(input logic [7:0] ix, input logic [7:0] d, input string tag);
        cyc(1'b1, ix, 1'b0, 1'b0, 1'b0, tag);
        cyc(1'b1, d,  1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic peek(input logic [7:0] ix, input string tag);
        cyc(1'b1, ix, 1'b0, 1'b0, 1'b0, tag);
        cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R1 index");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R1 reg0");
        // R2: index write drops bits 7:6
        cyc(1'b1, 8'hC5, 1'b0, 1'b0, 1'b0, "R2");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R2 index readback");
        // R3 / R5: reads in data phase do not toggle, then data write lands
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R5");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R5");
        cyc(1'b1, 8'h2A, 1'b0, 1'b0, 1'b0, "R3");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R3 readback");
        // R4: status read mid-pair restarts at index
        cyc(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, "R4");
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4");
        put(8'h11, 8'h77, "R4");
        peek(8'h11, "R4 border");
        // R4: write plus status read in the same cycle
        cyc(1'b1, 8'h13, 1'b1, 1'b0, 1'b0, "R4 same edge");
        put(8'h13, 8'h09, "R4 same edge");
        peek(8'h13, "R4 pan");
        // R7: reserved bits
        put(8'h10, 8'hFF, "R7"); peek(8'h10, "R7 mode");
        put(8'h12, 8'hFF, "R7"); peek(8'h12, "R7 plane");
        put(8'h14, 8'hFF, "R7"); peek(8'h14, "R7 csel");
        put(8'h0F, 8'hFF, "R7"); peek(8'h0F, "R7 palette");
        // R8: out-of-range index
        put(8'h15, 8'hAB, "R8"); peek(8'h15, "R8 read");
        put(8'h1F, 8'hCD, "R8"); peek(8'h14, "R8 neighbour");
        // R9 / R10: palette lock with source bit set
        put(8'h23, 8'h11, "R9"); peek(8'h23, "R9 locked");
        put(8'h30, 8'h5A, "R9"); peek(8'h30, "R9 mode open");
        cyc(1'b1, 8'h03, 1'b0, 1'b0, 1'b0, "R10");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R9 unlocked value");

        // random mix (R2 R3 R4 R5 R6 R8 R9 via model)
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] d;
            d = 8'($urandom());
            if ($urandom_range(0, 3) != 0) d[4:0] = 5'($urandom_range(0, 23));
            cyc($urandom_range(0, 1) == 1, d, $urandom_range(0, 9) == 0,
                $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R5/R6 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule